// File: doc/BRIEF.md
# NVRAM Region Checksum Engine

This block runs a 16-bit checksum over a stretch of a byte-wide memory and stores the result back into that same memory. A one-cycle start pulse launches a run. The pulse carries three values: a first address, a byte count and a destination address. The engine then owns a single memory port until the result is written. That port presents an address, receives the read byte one cycle later, and can write one byte per cycle.

The running sum begins at all ones. Each step mixes one 16-bit value into the sum using a nibble-folded update. The steps walk the region one byte at a time. Each step pairs the current byte (as the upper half) with the byte after it (as the lower half), so neighbouring words share a byte. When the count is odd, a last step uses the final byte as the upper half and zero as the lower half. The finished sum is written most-significant byte first.

Each byte is fetched once. Each overlapping word is formed from the byte fetched on the previous cycle and the byte arriving on this cycle. A run over N bytes therefore takes about N plus four cycles.

Top module: `nvsum_engine`

## Requirements
- R1: After reset, busy, done and the memory write enable are all low.
- R2: Every run begins with the sum at 0xFFFF. A byte count of zero writes 0xFFFF to the destination with no memory read, and busy stays high for exactly 2 cycles.
- R3: One update step with previous sum p and value v: let d = p XOR v, lo = d[3:0] and hi = d[7:4] XOR lo. The new sum is (p >> 8) XOR (lo << 3) XOR (lo << 8) XOR hi XOR (hi << 7) XOR (hi << 12), kept to 16 bits.
- R4: Let E be the count with bit 0 cleared. For i = 0 to E-1, step i uses the word whose upper byte is at first+i and whose lower byte is at first+i+1. When E > 0, busy lasts E+4 cycles for an even count.
- R5: For an odd count, one extra step follows, with value {byte at first+E, 8'h00}. A count of 1 keeps busy high for exactly 5 cycles.
- R6: The result's upper byte is written at the destination. On the next cycle its lower byte is written at the destination plus 1.
- R7: A start pulse that arrives while busy is high is ignored. It does not change the running job and produces no extra result or done pulse.
- R8: Done is high for exactly one cycle: the cycle right after the lower result byte is written.
- R9: Addresses are 13 bits. Both the read addresses and the destination plus 1 wrap modulo 8192.
- R10: Each run writes to memory exactly twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches a run when idle |
| src_addr | input | 13 | First byte of the region |
| byte_count | input | 14 | Number of bytes in the region |
| dst_addr | input | 13 | Where the upper result byte goes |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse after the result is stored |
| mem_addr | output | 13 | Memory address |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |

## Verification
Some behaviour is checked by assertions on every cycle:
- the sum is reloaded to 0xFFFF at each launch;
- the job registers do not move when a start arrives during busy;
- the lower-byte write follows the upper-byte write at the next address;
- done comes right after that second write and lasts a single cycle.

Other behaviour shows only in the bench scenarios:
- the arithmetic of the fold and the overlapping byte pairing, compared against a reference sum over a patterned memory;
- the trailing-byte rule for odd counts;
- the run lengths;
- wrapping at the top of the address space.

// File: rtl/nvsum_pkg.sv
package nvsum_pkg;
  localparam int unsigned ADDR_W = 13;
  localparam int unsigned CNT_W  = 14;
  localparam int unsigned SUM_W  = 16;
  localparam logic [SUM_W-1:0] SUM_SEED = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_FIN,
    ST_ODD,
    ST_WRH,
    ST_WRL
  } nvsum_state_e;
endpackage

// File: rtl/nvsum_fold.sv
module nvsum_fold (
  input  logic [15:0] prev_i,
  input  logic [15:0] val_i,
  output logic [15:0] next_o
);
  logic [15:0] mix;
  logic [3:0]  lo;
  logic [3:0]  hi;

  always_comb begin
    mix    = prev_i ^ val_i;
    lo     = mix[3:0];
    hi     = mix[7:4] ^ lo;
    next_o = {8'h00, prev_i[15:8]}
           ^ {9'b0, lo, 3'b0}
           ^ {4'b0, lo, 8'b0}
           ^ {12'b0, hi}
           ^ {5'b0, hi, 7'b0}
           ^ {hi, 12'b0};
  end
endmodule

// File: rtl/nvsum_acc.sv
module nvsum_acc
  import nvsum_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             cap_i,
  input  logic             pair_en_i,
  input  logic             odd_en_i,
  input  logic [7:0]       rdata_i,
  output logic [SUM_W-1:0] sum_o
);
  logic [SUM_W-1:0] sum_q, sum_d, step_val, fold_out;
  logic [7:0]       prev_q;
  logic             sum_en;

  always_comb begin
    step_val = odd_en_i ? {prev_q, 8'h00} : {prev_q, rdata_i};
    sum_en   = init_i | pair_en_i | odd_en_i;
    sum_d    = init_i ? SUM_SEED : fold_out;
  end

  nvsum_fold u_fold (
    .prev_i (sum_q),
    .val_i  (step_val),
    .next_o (fold_out)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= SUM_SEED;
      prev_q <= 8'h00;
    end else begin
      if (sum_en) sum_q  <= sum_d;
      if (cap_i)  prev_q <= rdata_i;
    end
  end

  assign sum_o = sum_q;

  AST_SEED_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_ni)
    init_i |=> (sum_q == SUM_SEED)); // R2
endmodule

// File: rtl/nvsum_ctrl.sv
module nvsum_ctrl
  import nvsum_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] dest_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              wr_hi_o,
  output logic              acc_init_o,
  output logic              acc_cap_o,
  output logic              acc_pair_o,
  output logic              acc_odd_o
);
  nvsum_state_e      state_q, state_d;
  logic [ADDR_W-1:0] base_q, dest_q;
  logic [CNT_W-1:0]  cnt_q, idx_q, idx_d, even_part, last_idx;
  logic              rd_vld_q, rd_first_q, done_q;
  logic              launch, rd_issue, job_en, idx_en;

  always_comb begin
    even_part  = {cnt_q[CNT_W-1:1], 1'b0};
    last_idx   = (even_part == '0) ? '0 : even_part;
    launch     = (state_q == ST_IDLE) && start_i;
    job_en     = launch;
    rd_issue   = (state_q == ST_RD);
    idx_en     = launch | rd_issue;
    idx_d      = launch ? '0 : idx_q + 1'b1;
    state_d    = state_q;
    mem_addr_o = '0;
    mem_we_o   = 1'b0;
    wr_hi_o    = 1'b0;
    acc_odd_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = (count_i == '0) ? ST_WRH : ST_RD;
      ST_RD: begin
        mem_addr_o = base_q + idx_q[ADDR_W-1:0];
        if (idx_q == last_idx) state_d = ST_FIN;
      end
      ST_FIN:  state_d = cnt_q[0] ? ST_ODD : ST_WRH;
      ST_ODD: begin
        acc_odd_o = 1'b1;
        state_d   = ST_WRH;
      end
      ST_WRH: begin
        mem_addr_o = dest_q;
        mem_we_o   = 1'b1;
        wr_hi_o    = 1'b1;
        state_d    = ST_WRL;
      end
      ST_WRL: begin
        mem_addr_o = dest_q + 1'b1;
        mem_we_o   = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      base_q     <= '0;
      dest_q     <= '0;
      cnt_q      <= '0;
      idx_q      <= '0;
      rd_vld_q   <= 1'b0;
      rd_first_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      rd_vld_q   <= rd_issue;
      rd_first_q <= rd_issue && (idx_q == '0);
      done_q     <= (state_q == ST_WRL);
      if (job_en) begin
        base_q <= base_i;
        dest_q <= dest_i;
        cnt_q  <= count_i;
      end
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign acc_init_o = launch;
  assign acc_cap_o  = rd_vld_q;
  assign acc_pair_o = rd_vld_q && !rd_first_q;

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(cnt_q) && $stable(base_q) && $stable(dest_q))); // R7
  AST_LOW_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_we_o && wr_hi_o) |=> (mem_we_o && !wr_hi_o && mem_addr_o == $past(mem_addr_o) + 1'b1)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |-> ($past(mem_we_o && !wr_hi_o) && !busy_o)); // R8
endmodule

// File: rtl/nvsum_engine.sv
module nvsum_engine
  import nvsum_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [ADDR_W-1:0] dst_addr,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        mem_wdata,
  output logic              mem_we
);
  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic             wr_hi, acc_init, acc_cap, acc_pair, acc_odd;
  logic [SUM_W-1:0] sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  nvsum_ctrl u_ctrl (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .base_i     (src_addr),
    .count_i    (byte_count),
    .dest_i     (dst_addr),
    .busy_o     (busy),
    .done_o     (done),
    .mem_addr_o (mem_addr),
    .mem_we_o   (mem_we),
    .wr_hi_o    (wr_hi),
    .acc_init_o (acc_init),
    .acc_cap_o  (acc_cap),
    .acc_pair_o (acc_pair),
    .acc_odd_o  (acc_odd)
  );

  nvsum_acc u_acc (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .init_i    (acc_init),
    .cap_i     (acc_cap),
    .pair_en_i (acc_pair),
    .odd_en_i  (acc_odd),
    .rdata_i   (mem_rdata),
    .sum_o     (sum)
  );

  assign mem_wdata = wr_hi ? sum[15:8] : sum[7:0];

  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_we |-> (busy && !done)); // R10
endmodule

// File: tb/test_nvsum_engine.sv
module test_nvsum_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [12:0] src_addr = '0;
  logic [13:0] byte_count = '0;
  logic [12:0] dst_addr = '0;
  logic        busy, done, mem_we;
  logic [12:0] mem_addr;
  logic [7:0]  mem_rdata, mem_wdata;
  logic [7:0]  mem [0:8191];

  int errors = 0;
  int checks = 0;
  int we_seen = 0;
  bit finished = 0;

  typedef struct { logic [12:0] dest; logic [15:0] sum; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  nvsum_engine i_nvsum_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
    .byte_count(byte_count), .dst_addr(dst_addr), .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] step(input logic [15:0] p, input logic [15:0] v);
    logic [15:0] d, lo, hi;
    d  = p ^ v;
    lo = d & 16'h000F;
    hi = ((d >> 4) & 16'h000F) ^ lo;
    return (p >> 8) ^ (lo << 3) ^ (lo << 8) ^ hi ^ (hi << 7) ^ (hi << 12);
  endfunction

  function automatic logic [15:0] ref_sum(input int s, input int n);
    logic [15:0] c;
    int ev;
    c  = 16'hFFFF;
    ev = n & ~1;
    for (int i = 0; i < ev; i++)
      c = step(c, {mem[(s + i) % 8192], mem[(s + i + 1) % 8192]});
    if (n & 1) c = step(c, {mem[(s + ev) % 8192], 8'h00});
    return c;
  endfunction

  // Monitor: pops one expected item for each done pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) we_seen++;
      if (done) begin
        check(we_seen == 2, "R10 writes per run", we_seen, 2);
        we_seen = 0;
        if (exp_q.size() == 0) begin
          check(0, "R7 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(mem[e.dest] == e.sum[15:8], "R3 R6 upper byte", mem[e.dest], e.sum[15:8]);
          check(mem[(e.dest + 1) % 8192] == e.sum[7:0], "R3 R6 R9 lower byte",
                mem[(e.dest + 1) % 8192], e.sum[7:0]);
        end
      end
    end
  end

  task automatic run_job(input int s, input int n, input int d, input int stray_at,
                         output int cycles);
    exp_t e;
    e.dest = d[12:0];
    e.sum  = ref_sum(s, n);
    exp_q.push_back(e);
    @(negedge clk);
    src_addr = s[12:0]; byte_count = n[13:0]; dst_addr = d[12:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 0;
    while (busy && cycles < 20000) begin
      cycles++;
      if (cycles == stray_at) begin
        start = 1'b1; src_addr = 13'h0; byte_count = 14'd3; dst_addr = 13'h0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(done == 1'b1, "R8 done after writes", done, 1);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", done, 0);
  endtask

  initial begin
    int cyc;
    for (int i = 0; i < 8192; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 5));
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_we, "R1 reset outputs", {busy, done, mem_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && !mem_we, "R1 after release", {busy, done, mem_we}, 0);

    run_job(16'h40, 0, 16'h1000, 0, cyc);
    check(cyc == 2, "R2 zero count busy", cyc, 2);
    run_job(16'h10, 1, 16'h1010, 0, cyc);
    check(cyc == 5, "R5 single byte busy", cyc, 5);
    run_job(16'h20, 2, 16'h1020, 0, cyc);
    check(cyc == 6, "R4 two bytes busy", cyc, 6);
    run_job(16'h30, 7, 16'h1030, 0, cyc);
    run_job(16'h80, 32, 16'h1040, 0, cyc);
    check(cyc == 36, "R4 32 bytes busy", cyc, 36);
    run_job(16'h200, 513, 16'h1050, 0, cyc);
    run_job(16'h1FFC, 9, 16'h1060, 0, cyc);   // R9 read wrap
    run_job(16'h300, 12, 16'h1FFF, 0, cyc);   // R9 destination wrap
    run_job(16'h400, 40, 16'h1070, 5, cyc);   // R7 stray start
    check(cyc == 44, "R7 run length unchanged", cyc, 44);
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R7 R8 all results seen", exp_q.size(), 0);
    check(!busy, "R7 idle after stray start", busy, 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule